// File: doc/BRIEF.md
# USB Bridge Endpoint FIFO Bus Master

This block sits in the FPGA and is the master of the parallel FIFO port of a USB 2.0 bridge chip. The bridge is run in a mode where the FPGA drives all of the strobes. The bridge exposes four endpoint FIFOs, and the block selects one at a time through a 2-bit endpoint select. Three of the endpoints carry data from the host: the command header, the command and the compressed bitstream. The fourth returns decoded results to the host. The bridge reports only the empty and full state of whichever endpoint is selected at that moment. The block therefore polls the endpoints one after another. After each change of select it waits one settling clock before it acts on the flags.

Inbound words are pulled with output-enable and read strobes and routed to one of three internal streams, one stream per inbound role. A stream that is not ready keeps its endpoint from being read. Result words are pushed with a write strobe while the block drives the bus. When a result transfer ends on a byte count that does not fill the last 512-byte packet, the block pulses a commit strobe. This makes the bridge send the short packet to the host at once. The bus width is 8 or 16 bits, chosen by a parameter. The byte count of each word follows from that width.

Top module: `usb_bridge_fifo_master`

## Requirements
- R1: While reset is held and right after it, every bridge strobe (bus_oe_n, bus_rd_n, bus_wr_n, commit_n) is high, bus_drive is 0 and rx_valid is 0.
- R2: The endpoint select encodes 2'b00 = command header, 2'b01 = bitstream, 2'b10 = command, 2'b11 = result. Any read or write strobe is sampled with the same select value that was present at the clock edge before.
- R3: bus_oe_n is low only while an inbound endpoint (select 00, 01 or 10) is selected.
- R4: bus_drive is 1 only while the result endpoint (select 11) is selected and bus_oe_n is high.
- R5: A read strobe is issued only while the selected endpoint is not empty and bus_oe_n is low. The word read appears on rx_data one clock later, with a single rx_valid bit: bit 0 for the header, bit 1 for the command, bit 2 for the bitstream.
- R6: Service priority is result (when res_valid is high), then header, then command, then bitstream. An endpoint is drained while it keeps its flag, and after a transfer the search restarts from the top of this order.
- R7: A write strobe is issued only while the result endpoint is selected, it is not full, and res_valid is high. res_ready is high in exactly those cycles, and bus_out carries res_data. No word is lost or repeated across full stalls.
- R8: commit_n goes low for exactly one clock, with the result endpoint still selected, in the cycle after the word marked res_last is written, if the transfer's byte count is not a multiple of 512. It does not go low if the count is a multiple of 512.
- R9: Each written word counts BUS_W/8 bytes. With a 16-bit bus, 256 words end without a commit pulse and 128 words end with one.
- R10: An inbound endpoint whose stream has its rx_ready bit low (bit order as in R5) is not read, and its data stays in the bridge until the bit rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_sel | output | 2 | Endpoint select to the bridge |
| bus_oe_n | output | 1 | Active-low bridge output enable |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| commit_n | output | 1 | Active-low short-packet commit |
| sel_empty | input | 1 | Selected endpoint is empty |
| sel_full | input | 1 | Selected endpoint is full |
| bus_in | input | BUS_W | Data from the bridge |
| bus_out | output | BUS_W | Data to the bridge |
| bus_drive | output | 1 | Enable for the bus pad drivers |
| rx_ready | input | 3 | Inbound streams can accept a word |
| rx_data | output | BUS_W | Inbound word |
| rx_valid | output | 3 | One-hot role of rx_data |
| res_data | input | BUS_W | Result word |
| res_valid | input | 1 | Result word waiting |
| res_last | input | 1 | Result word ends the transfer |
| res_ready | output | 1 | Result word taken this cycle |

## Verification
The bench models the bridge as four FIFOs indexed by the select, so a wrong select encoding shows up as data arriving on the wrong stream. A strobe issued in the same cycle as a select change would read or write the previous endpoint, and the model counts it. All three inbound endpoints are loaded and released together with a result word waiting, and the recorded access order must be result, header, command, bitstream. An arbiter that failed to rescan from the top, or that ignored priority, would interleave them. Result transfers of 128 and 256 sixteen-bit words separate a byte-based packet count from a word-based one. A stall on the full flag in the middle of a transfer catches writes issued while full and commit pulses decided on a count that was reset.

// File: rtl/usbm_pkg.sv
package usbm_pkg;

    typedef enum logic [1:0] {
        PH_SCAN,
        PH_HOLD,
        PH_XFER,
        PH_COMMIT
    } phase_t;

    // priority slots: 0 result, 1 header, 2 command, 3 bitstream
    localparam int NUM_SLOTS  = 4;
    localparam int SLOT_W     = 2;
    localparam int NUM_STREAMS = 3;

    typedef struct packed {
        phase_t             phase;
        logic [SLOT_W-1:0]  slot;
        logic [1:0]         sel;
        logic [SLOT_W-1:0]  start;
        logic               moved;
    } ctrl_t;

    function automatic logic [1:0] slot_to_sel(input logic [SLOT_W-1:0] s);
        logic [1:0] r;
        case (s)
            2'd0:    r = 2'b11;
            2'd1:    r = 2'b00;
            2'd2:    r = 2'b10;
            default: r = 2'b01;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/usbm_scan_arb.sv
module usbm_scan_arb #(
    parameter int N  = 4,
    parameter int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [SW-1:0] start,
    input  logic [N-1:0]  elig,
    output logic          found,
    output logic [SW-1:0] pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i] && (i >= int'(start))) begin
                found = 1'b1;
                pick  = SW'(i);
            end
        end
    end
endmodule

// File: rtl/usbm_pkt_track.sv
module usbm_pkt_track #(
    parameter int BUS_W     = 16,
    parameter int PKT_BYTES = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic last,
    output logic short_end
);
    localparam int BPW = BUS_W / 8;
    localparam int CW  = $clog2(PKT_BYTES) + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] sum;
    logic [CW-1:0] wrapped;

    always_comb begin
        sum     = cnt_q + CW'(BPW);
        wrapped = (sum >= CW'(PKT_BYTES)) ? (sum - CW'(PKT_BYTES)) : sum;
        short_end = fire && last && (wrapped != '0);
        cnt_d = cnt_q;
        if (fire) begin
            cnt_d = last ? '0 : wrapped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/usbm_rx_route.sv
module usbm_rx_route #(
    parameter int BUS_W = 16,
    parameter int NS    = 3,
    parameter int IW    = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [IW-1:0]    idx,
    input  logic [BUS_W-1:0] din,
    output logic [BUS_W-1:0] rx_data,
    output logic [NS-1:0]    rx_valid
);
    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic [NS-1:0]    valid;
    } rx_t;

    rx_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = '0;
        if (fire) begin
            r_d.data = din;
            for (int k = 0; k < NS; k++) begin
                r_d.valid[k] = (int'(idx) == k);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_data  = r_q.data;
    assign rx_valid = r_q.valid;
endmodule

// File: rtl/usb_bridge_fifo_master.sv
module usb_bridge_fifo_master
    import usbm_pkg::*;
#(
    parameter int BUS_W     = 16,
    parameter int PKT_BYTES = 512
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [1:0]             ep_sel,
    output logic                   bus_oe_n,
    output logic                   bus_rd_n,
    output logic                   bus_wr_n,
    output logic                   commit_n,
    input  logic                   sel_empty,
    input  logic                   sel_full,
    input  logic [BUS_W-1:0]       bus_in,
    output logic [BUS_W-1:0]       bus_out,
    output logic                   bus_drive,
    input  logic [NUM_STREAMS-1:0] rx_ready,
    output logic [BUS_W-1:0]       rx_data,
    output logic [NUM_STREAMS-1:0] rx_valid,
    input  logic [BUS_W-1:0]       res_data,
    input  logic                   res_valid,
    input  logic                   res_last,
    output logic                   res_ready
);
    localparam int IW = $clog2(NUM_STREAMS);

    ctrl_t c_d, c_q;

    logic [NUM_SLOTS-1:0] elig;
    logic                 found;
    logic [SLOT_W-1:0]    pick;
    logic                 inbound;
    logic [IW-1:0]        sidx;
    logic                 rd_fire;
    logic                 wr_fire;
    logic                 short_end;

    assign elig = {rx_ready[2], rx_ready[1], rx_ready[0], res_valid};

    usbm_scan_arb #(.N(NUM_SLOTS), .SW(SLOT_W)) u_arb (
        .start (c_q.start),
        .elig  (elig),
        .found (found),
        .pick  (pick)
    );

    always_comb begin
        inbound = (c_q.slot != '0);
        sidx    = IW'(c_q.slot - SLOT_W'(1));
        rd_fire = (c_q.phase == PH_XFER) && inbound && !sel_empty && rx_ready[sidx];
        wr_fire = (c_q.phase == PH_XFER) && !inbound && !sel_full && res_valid;
    end

    usbm_pkt_track #(.BUS_W(BUS_W), .PKT_BYTES(PKT_BYTES)) u_pkt (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (wr_fire),
        .last      (res_last),
        .short_end (short_end)
    );

    usbm_rx_route #(.BUS_W(BUS_W), .NS(NUM_STREAMS), .IW(IW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (rd_fire),
        .idx      (sidx),
        .din      (bus_in),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    always_comb begin
        c_d = c_q;
        unique case (c_q.phase)
            PH_SCAN: begin
                if (found) begin
                    c_d.slot  = pick;
                    c_d.sel   = slot_to_sel(pick);
                    c_d.phase = PH_HOLD;
                end else begin
                    c_d.start = '0;
                end
            end
            PH_HOLD: begin
                c_d.phase = PH_XFER;
                c_d.moved = 1'b0;
            end
            PH_XFER: begin
                if (rd_fire) begin
                    c_d.moved = 1'b1;
                end else if (wr_fire) begin
                    c_d.moved = 1'b1;
                    if (res_last) begin
                        c_d.phase = short_end ? PH_COMMIT : PH_SCAN;
                        c_d.start = '0;
                    end
                end else begin
                    c_d.phase = PH_SCAN;
                    c_d.start = c_q.moved ? '0 : (c_q.slot + SLOT_W'(1));
                end
            end
            PH_COMMIT: begin
                c_d.phase = PH_SCAN;
                c_d.start = '0;
            end
            default: c_d.phase = PH_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{phase: PH_SCAN, slot: '0, sel: 2'b00, start: '0, moved: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign ep_sel    = c_q.sel;
    assign bus_oe_n  = !(((c_q.phase == PH_HOLD) || (c_q.phase == PH_XFER)) && inbound);
    assign bus_rd_n  = !rd_fire;
    assign bus_wr_n  = !wr_fire;
    assign commit_n  = !(c_q.phase == PH_COMMIT);
    assign bus_drive = (c_q.phase == PH_XFER) && !inbound;
    assign bus_out   = res_data;
    assign res_ready = wr_fire;

endmodule

// File: rtl/usbm_checker.sv
module usbm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ep_sel,
    input logic       bus_oe_n,
    input logic       bus_rd_n,
    input logic       bus_wr_n,
    input logic       commit_n,
    input logic       bus_drive,
    input logic       sel_empty,
    input logic       sel_full,
    input logic       res_valid
);
    // R2
    sel_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> (ep_sel == $past(ep_sel)));

    // R3
    oe_inbound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_n |-> (ep_sel != 2'b11));

    // R4
    drive_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> (ep_sel == 2'b11 && bus_oe_n));

    // R5
    read_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> (!sel_empty && !bus_oe_n && bus_wr_n));

    // R7
    write_notfull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> (!sel_full && res_valid && bus_drive));

    // R8
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_n |=> commit_n);

    // R8
    commit_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_n |-> (ep_sel == 2'b11));
endmodule

bind usb_bridge_fifo_master usbm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ep_sel    (ep_sel),
    .bus_oe_n  (bus_oe_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .commit_n  (commit_n),
    .bus_drive (bus_drive),
    .sel_empty (sel_empty),
    .sel_full  (sel_full),
    .res_valid (res_valid)
);

// File: tb/usb_bridge_fifo_master_bench.sv
module usb_bridge_fifo_master_bench;
    localparam int BW = 16;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [1:0]    ep_sel;
    logic          bus_oe_n, bus_rd_n, bus_wr_n, commit_n, bus_drive;
    logic          sel_empty, sel_full;
    logic [BW-1:0] bus_in, bus_out, rx_data, res_data;
    logic [2:0]    rx_ready, rx_valid;
    logic          res_valid, res_last, res_ready;

    usb_bridge_fifo_master #(.BUS_W(BW), .PKT_BYTES(512)) u_usb_bridge_fifo_master (
        .clk(clk), .rst_n(rst_n), .ep_sel(ep_sel), .bus_oe_n(bus_oe_n),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .commit_n(commit_n),
        .sel_empty(sel_empty), .sel_full(sel_full), .bus_in(bus_in),
        .bus_out(bus_out), .bus_drive(bus_drive), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .res_data(res_data),
        .res_valid(res_valid), .res_last(res_last), .res_ready(res_ready)
    );

    always #2 clk = ~clk;

    // bridge model: inbound FIFOs indexed by select 00/01/10
    logic [BW-1:0] mem_in [3][64];
    int in_wr [3] = '{0, 0, 0};
    int in_rd [3] = '{0, 0, 0};
    logic [BW-1:0] mem8 [512];
    int ep8_cnt = 0;
    int ep8_cap = 100000;
    int commit_cnt = 0;
    int v_settle = 0, v_oe = 0, v_drive = 0, v_rd = 0, v_wr = 0, v_cm = 0;
    logic [1:0] prev_sel = 2'b00;
    logic [BW-1:0] got [3][64];
    int got_n [3] = '{0, 0, 0};
    byte ev [128];
    int ev_n = 0;

    int checks = 0, errors = 0;
    bit done = 0;
    bit res_done = 0;

    assign sel_empty = (ep_sel == 2'b11) ? 1'b0 : (in_rd[ep_sel] == in_wr[ep_sel]);
    assign sel_full  = (ep_sel == 2'b11) ? (ep8_cnt >= ep8_cap) : 1'b0;
    assign bus_in    = (!bus_oe_n && ep_sel != 2'b11) ? mem_in[ep_sel][in_rd[ep_sel] % 64] : '0;

    always @(posedge clk) begin
        if (rst_n) begin
            prev_sel <= ep_sel;
            if ((!bus_rd_n || !bus_wr_n) && ep_sel != prev_sel) v_settle <= v_settle + 1;
            if (!bus_oe_n && ep_sel == 2'b11) v_oe <= v_oe + 1;
            if (bus_drive && ep_sel != 2'b11) v_drive <= v_drive + 1;
            if (!bus_rd_n) begin
                if (bus_oe_n || ep_sel == 2'b11 || sel_empty) v_rd <= v_rd + 1;
                else begin
                    in_rd[ep_sel] <= in_rd[ep_sel] + 1;
                    ev[ev_n % 128] <= (ep_sel == 2'b00) ? "H" : (ep_sel == 2'b10) ? "C" : "B";
                    ev_n <= ev_n + 1;
                end
            end
            if (!bus_wr_n) begin
                if (sel_full || !bus_drive || ep_sel != 2'b11) v_wr <= v_wr + 1;
                mem8[ep8_cnt % 512] <= bus_out;
                ep8_cnt <= ep8_cnt + 1;
                ev[ev_n % 128] <= "W";
                ev_n <= ev_n + 1;
            end
            if (!commit_n) begin
                commit_cnt <= commit_cnt + 1;
                if (ep_sel != 2'b11) v_cm <= v_cm + 1;
            end
            for (int k = 0; k < 3; k++) begin
                if (rx_valid[k]) begin
                    got[k][got_n[k] % 64] <= rx_data;
                    got_n[k] <= got_n[k] + 1;
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // q: 0 header(sel 00), 1 bitstream(sel 01), 2 command(sel 10)
    task automatic load(input int q, input int n, input logic [BW-1:0] b);
        for (int i = 0; i < n; i++) mem_in[q][(in_wr[q] + i) % 64] = b + BW'(i);
        in_wr[q] = in_wr[q] + n;
    endtask

    task automatic send_res(input int n, input logic [BW-1:0] b);
        bit ok;
        res_done = 0;
        for (int i = 0; i < n; i++) begin
            res_data  = b + BW'(i);
            res_last  = (i == n - 1);
            res_valid = 1;
            do begin
                @(negedge clk); #1;
                ok = res_ready;
            end while (!ok);
            @(posedge clk); #1;
        end
        res_valid = 0;
        res_last  = 0;
        res_done  = 1;
    endtask

    task automatic t_reset;
        chk("R1", {bus_oe_n, bus_rd_n, bus_wr_n, commit_n}, 4'hF, "strobes in reset");
        chk("R1", {bus_drive, rx_valid}, 0, "drive/valid in reset");
        rst_n = 1;
        cycles(3);
        chk("R1", {bus_rd_n, bus_wr_n, commit_n, bus_drive}, 4'hE, "idle after reset");
        chk("R1", rx_valid, 0, "rx_valid after reset");
    endtask

    task automatic t_route;
        int b0 = got_n[0], b1 = got_n[1], b2 = got_n[2];
        int bad = 0;
        load(0, 4, 16'h1100);
        cycles(30);
        load(1, 3, 16'h4400);
        cycles(30);
        load(2, 2, 16'h6600);
        cycles(30);
        chk("R5", got_n[0] - b0, 4, "header words");
        chk("R2", got_n[2] - b2, 3, "bitstream words via select 01");
        chk("R2", got_n[1] - b1, 2, "command words via select 10");
        for (int i = 0; i < 4; i++) if (got[0][(b0 + i) % 64] != 16'h1100 + BW'(i)) bad++;
        for (int i = 0; i < 3; i++) if (got[2][(b2 + i) % 64] != 16'h4400 + BW'(i)) bad++;
        for (int i = 0; i < 2; i++) if (got[1][(b1 + i) % 64] != 16'h6600 + BW'(i)) bad++;
        chk("R5", bad, 0, "routed data mismatches");
    endtask

    task automatic t_prio;
        string exp = "WHHHCCCBBB";
        int base, bad = 0, c0 = commit_cnt, w0 = ep8_cnt;
        rx_ready = 3'b000;
        cycles(6);
        load(0, 3, 16'h2000);
        load(2, 3, 16'h3000);
        load(1, 3, 16'h5000);
        base = ev_n;
        rx_ready  = 3'b111;
        res_data  = 16'hBEEF;
        res_last  = 1;
        res_valid = 1;
        while (ep8_cnt == w0) @(negedge clk);
        res_valid = 0;
        res_last  = 0;
        cycles(40);
        chk("R6", ev_n - base, 10, "access count");
        for (int i = 0; i < 10; i++) if (ev[(base + i) % 128] != exp[i]) bad++;
        chk("R6", bad, 0, "access order mismatches");
        chk("R8", commit_cnt - c0, 1, "commit after single word");
        chk("R7", int'(mem8[w0 % 512]), 16'hBEEF, "result word");
    endtask

    task automatic t_res(input int n, input int exp_commit, input string req);
        int c0 = commit_cnt, w0 = ep8_cnt, bad = 0;
        send_res(n, 16'h7000);
        cycles(6);
        chk(req, ep8_cnt - w0, n, "result words written");
        for (int i = 0; i < n; i++) if (mem8[(w0 + i) % 512] != 16'h7000 + BW'(i)) bad++;
        chk("R7", bad, 0, "result data mismatches");
        chk(req, commit_cnt - c0, exp_commit, "commit pulses");
    endtask

    task automatic t_full;
        int c0 = commit_cnt, w0 = ep8_cnt, bad = 0;
        ep8_cap = ep8_cnt + 2;
        fork
            send_res(5, 16'h9000);
        join_none
        cycles(40);
        chk("R7", ep8_cnt - w0, 2, "writes while full");
        chk("R8", commit_cnt - c0, 0, "no commit during stall");
        ep8_cap = 100000;
        while (!res_done) @(negedge clk);
        cycles(6);
        chk("R7", ep8_cnt - w0, 5, "words after release");
        for (int i = 0; i < 5; i++) if (mem8[(w0 + i) % 512] != 16'h9000 + BW'(i)) bad++;
        chk("R7", bad, 0, "data across stall");
        chk("R8", commit_cnt - c0, 1, "commit after stalled short transfer");
    endtask

    task automatic t_backpressure;
        int b0 = got_n[0], b1 = got_n[1], r2 = in_rd[2];
        rx_ready = 3'b101;
        load(2, 2, 16'hC000);
        load(0, 1, 16'hA000);
        cycles(40);
        chk("R10", got_n[0] - b0, 1, "ready header read");
        chk("R10", in_rd[2] - r2, 0, "blocked command not read");
        chk("R10", got_n[1] - b1, 0, "blocked command not delivered");
        rx_ready = 3'b111;
        cycles(30);
        chk("R10", got_n[1] - b1, 2, "command after ready");
        chk("R10", int'(got[1][b1 % 64]), 16'hC000, "first command word");
    endtask

    initial begin
        rx_ready = 3'b111;
        res_data = '0; res_valid = 0; res_last = 0;
        cycles(4);
        t_reset();
        t_route();
        t_prio();
        t_res(5, 1, "R8");
        t_res(256, 0, "R9");
        t_res(128, 1, "R9");
        t_full();
        t_backpressure();
        chk("R2", v_settle, 0, "strobes on unsettled select");
        chk("R3", v_oe, 0, "output enable on result select");
        chk("R4", v_drive, 0, "drive on inbound select");
        chk("R5", v_rd, 0, "bad reads");
        chk("R7", v_wr, 0, "bad writes");
        chk("R8", v_cm, 0, "commit on wrong select");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule